// File: doc/BRIEF.md
# Clear-on-Match Timer Counter

A 16-bit up-counter for a small microcontroller timer. On each timer tick it advances by one. The counter either runs to full scale and wraps to zero, or, when the clear-on-match control bit is set, returns to zero on the tick that finds the count equal to a 16-bit compare register. The tick source is picked by a 3-bit clock-select field: stopped, every clock, one of four prescaler strobes supplied from outside, or a synchronized edge of an external pin.

Software reaches the count and the compare value over an 8-bit bus. A shared temporary byte makes 16-bit accesses atomic. Reading the count's low byte captures the high byte into the temporary byte. A write to a high byte lands in the temporary byte, and the full word is committed when the matching low byte is written. A commit to the count always beats a same-cycle increment or clear. An overflow flag is set whenever the count passes full scale. It drives an interrupt request line and is cleared by writing a one to it.

Top module: `ctm_timer`

## Requirements
- R1: With the clear-on-match bit at 0, every tick adds one to the count, and the count wraps from 0xFFFF to 0x0000.
- R2: With the clear-on-match bit (control bit 3) at 1, a tick while the count equals the compare value loads zero. A count above the compare value keeps counting up to 0xFFFF and wraps.
- R3: Clock-select value 0 (control bits 2:0) stops the counter. Prescaler strobes and pin edges then have no effect, and the count can still be read and written.
- R4: Clock-select 1 ticks on every clock. Values 2, 3, 4 and 5 tick on presTick bits 0, 1, 2 and 3.
- R5: Clock-select 6 ticks once per falling edge of extIn, and 7 once per rising edge. Each edge is synchronized and moves the count within three clocks.
- R6: A tick taken while the count is 0xFFFF sets the overflow flag. The flag reads as bit 0 at address 5 and drives ovfIrq. A set beats a same-cycle clear.
- R7: Writing 1 to bit 0 at address 5 clears the overflow flag. Writing 0 leaves it unchanged.
- R8: A count commit (write to address 0) takes priority over a same-cycle increment or clear and suppresses that cycle's overflow set.
- R9: A read of address 0 copies the count's high byte into the temporary byte, and a read of address 1 returns the temporary byte. Writes to address 1 or 3 load the temporary byte. A write to address 0 or 2 commits {temporary, data} to the count or compare register. Addresses 2 and 3 read the compare bytes directly.
- R10: After reset the count, compare value, control register (address 4) and flag are zero. Addresses 6 and 7 read as zero, and address 4 reads back {0000, clear-on-match, clock-select}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe (side effect at address 0) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| presTick | input | 4 | Prescaler strobes for divide by 8, 64, 256 and 1024 |
| extIn | input | 1 | External clock pin, asynchronous |
| ovfIrq | output | 1 | Overflow interrupt request (flag state) |

## Verification
The clear-on-match wrap is swept over a set of compare values and run lengths, with the expected count computed as a modulo sum. This separates a clear taken on the match from a clear taken one tick late or early. Runs that start just below full scale, in both modes, tell the free-running wrap and the flag set apart from the above-compare case. Prescaler strobes held in a fixed pattern show which tap each select value decodes. Pin toggles counted under both edge selects show that the right edge is taken and that it is taken only once. Commits issued while the counter runs, and reads taken around a run, show write priority and the atomicity of the temporary byte.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT_L = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_H = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP_L = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_H = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd5;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic cntLoad;     // commit {temp, wrData} to count
    logic cntClr;      // clear on match
    logic cntInc;      // increment
    logic cmpLoad;     // commit {temp, wrData} to compare
    logic tmpFromBus;  // high byte write into temp
    logic tmpFromCnt;  // low byte read snapshot of count high
    logic ovfSet;
    logic ovfClr;
  } ctl_t;
endpackage

// File: rtl/ctm_ctrl.sv
module ctm_ctrl
  import ctm_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int NUM_PRES = 4,
  parameter int SYNC_N   = 2,
  parameter int BUS_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [NUM_PRES-1:0] presTick,
  input  logic              extIn,
  input  logic              matchCmp,
  input  logic              atMax,
  output ctl_t              ctl,
  output logic [SEL_W-1:0]  selQ,
  output logic              ctmQ
);
  localparam int SRC_N = 2 ** SEL_W;

  logic [SYNC_N-1:0] syncQ;
  logic              extPrev;
  logic              extRise;
  logic              extFall;
  logic [SRC_N-1:0]  srcVec;
  logic              tick;
  logic              cntWr;

  // pin synchronizer and edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      extPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_N-2:0], extIn};
      extPrev <= syncQ[SYNC_N-1];
    end
  end

  assign extRise = syncQ[SYNC_N-1] & ~extPrev;
  assign extFall = ~syncQ[SYNC_N-1] & extPrev;

  // tick source table by select value
  for (genvar k = 0; k < SRC_N; k++) begin : g_src
    if (k == 0) begin : g_stop
      assign srcVec[k] = 1'b0;
    end else if (k == 1) begin : g_direct
      assign srcVec[k] = 1'b1;
    end else if (k < 2 + NUM_PRES) begin : g_pres
      assign srcVec[k] = presTick[k-2];
    end else if (k == SRC_N - 2) begin : g_fall
      assign srcVec[k] = extFall;
    end else if (k == SRC_N - 1) begin : g_rise
      assign srcVec[k] = extRise;
    end else begin : g_none
      assign srcVec[k] = 1'b0;
    end
  end

  assign tick = srcVec[selQ];

  // control register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      ctmQ <= 1'b0;
    end else if (wrEn && addr == A_CTRL) begin
      selQ <= wrData[SEL_W-1:0];
      ctmQ <= wrData[SEL_W];
    end
  end

  assign cntWr = wrEn && (addr == A_CNT_L);

  always_comb begin
    ctl            = '0;
    ctl.cntLoad    = cntWr;
    ctl.cntClr     = !cntWr && tick && ctmQ && matchCmp;
    ctl.cntInc     = !cntWr && tick && !(ctmQ && matchCmp);
    ctl.ovfSet     = !cntWr && tick && atMax;
    ctl.ovfClr     = wrEn && (addr == A_FLAG) && wrData[0];
    ctl.cmpLoad    = wrEn && (addr == A_CMP_L);
    ctl.tmpFromBus = wrEn && (addr == A_CNT_H || addr == A_CMP_H);
    ctl.tmpFromCnt = !ctl.tmpFromBus && rdEn && (addr == A_CNT_L);
  end
endmodule

// File: rtl/ctm_dpath.sv
module ctm_dpath
  import ctm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [SEL_W-1:0]  selQ,
  input  logic              ctmQ,
  output logic [CNT_W-1:0]  countQ,
  output logic [CNT_W-1:0]  cmpQ,
  output logic [CNT_W-BUS_W-1:0] tempQ,
  output logic              ovfQ,
  output logic              matchCmp,
  output logic              atMax,
  output logic [BUS_W-1:0]  rdData
);
  localparam int HI_W = CNT_W - BUS_W;
  localparam int PAD_W = BUS_W - SEL_W - 1;

  logic [CNT_W-1:0] wordIn;

  assign wordIn   = {tempQ, wrData};
  assign matchCmp = (countQ == cmpQ);
  assign atMax    = &countQ;

  // count register: commit beats clear beats increment
  always_ff @(posedge clk) begin
    if (!rstN)            countQ <= '0;
    else if (ctl.cntLoad) countQ <= wordIn;
    else if (ctl.cntClr)  countQ <= '0;
    else if (ctl.cntInc)  countQ <= countQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cmpQ <= '0;
    else if (ctl.cmpLoad) cmpQ <= wordIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               tempQ <= '0;
    else if (ctl.tmpFromBus) tempQ <= wrData[HI_W-1:0];
    else if (ctl.tmpFromCnt) tempQ <= countQ[CNT_W-1:BUS_W];
  end

  // flag: set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)           ovfQ <= 1'b0;
    else if (ctl.ovfSet) ovfQ <= 1'b1;
    else if (ctl.ovfClr) ovfQ <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_CNT_L: rdData = countQ[BUS_W-1:0];
      A_CNT_H: rdData = BUS_W'(tempQ);
      A_CMP_L: rdData = cmpQ[BUS_W-1:0];
      A_CMP_H: rdData = BUS_W'(cmpQ[CNT_W-1:BUS_W]);
      A_CTRL:  rdData = {{PAD_W{1'b0}}, ctmQ, selQ};
      A_FLAG:  rdData = {{(BUS_W-1){1'b0}}, ovfQ};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ctm_timer.sv
module ctm_timer
  import ctm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int BUS_W    = 8,
  parameter int SEL_W    = 3,
  parameter int NUM_PRES = 4,
  parameter int SYNC_N   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W-1:0]    wrData,
  output logic [BUS_W-1:0]    rdData,
  input  logic [NUM_PRES-1:0] presTick,
  input  logic                extIn,
  output logic                ovfIrq
);
  ctl_t                   ctl;
  logic [SEL_W-1:0]       selQ;
  logic                   ctmQ;
  logic [CNT_W-1:0]       countQ;
  logic [CNT_W-1:0]       cmpQ;
  logic [CNT_W-BUS_W-1:0] tempQ;
  logic                   ovfQ;
  logic                   matchCmp;
  logic                   atMax;

  ctm_ctrl #(
    .SEL_W(SEL_W), .NUM_PRES(NUM_PRES), .SYNC_N(SYNC_N), .BUS_W(BUS_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .presTick(presTick), .extIn(extIn),
    .matchCmp(matchCmp), .atMax(atMax), .ctl(ctl), .selQ(selQ), .ctmQ(ctmQ)
  );

  ctm_dpath #(
    .CNT_W(CNT_W), .BUS_W(BUS_W), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr), .wrData(wrData),
    .selQ(selQ), .ctmQ(ctmQ), .countQ(countQ), .cmpQ(cmpQ), .tempQ(tempQ),
    .ovfQ(ovfQ), .matchCmp(matchCmp), .atMax(atMax), .rdData(rdData)
  );

  assign ovfIrq = ovfQ;
endmodule

// File: rtl/ctm_chk.sv
module ctm_chk
  import ctm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  parameter int SEL_W = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [ADDR_W-1:0]      addr,
  input logic [BUS_W-1:0]       wrData,
  input logic [CNT_W-1:0]       countQ,
  input logic [CNT_W-1:0]       cmpQ,
  input logic [CNT_W-BUS_W-1:0] tempQ,
  input logic [SEL_W-1:0]       selQ,
  input logic                   ctmQ,
  input logic                   ovfIrq
);
  logic cntWr;
  logic flagClr;
  assign cntWr   = wrEn && (addr == A_CNT_L);
  assign flagClr = wrEn && (addr == A_FLAG) && wrData[0];

  AST_FREE_INC: assert property (@(posedge clk) disable iff (!rstN)
    (!ctmQ && selQ == SEL_W'(1) && !cntWr) |=> (countQ == CNT_W'($past(countQ) + 1'b1))); // R1

  AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ctmQ && selQ == SEL_W'(1) && countQ == cmpQ && !cntWr) |=> (countQ == '0)); // R2

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (selQ == '0 && !cntWr) |=> $stable(countQ)); // R3

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (countQ == {$past(tempQ), $past(wrData)})); // R8

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (selQ == SEL_W'(1) && (&countQ) && !cntWr) |=> ovfIrq); // R6

  AST_OVF_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (ovfIrq && !flagClr) |=> ovfIrq); // R7
endmodule

bind ctm_timer ctm_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .countQ(countQ), .cmpQ(cmpQ), .tempQ(tempQ), .selQ(selQ), .ctmQ(ctmQ),
  .ovfIrq(ovfIrq)
);

// File: tb/ctm_timer_tb.sv
`timescale 1ns/1ps
module ctm_timer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [3:0] presTick = '0;
  logic       extIn = 1'b0;
  logic       ovfIrq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctm_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .presTick(presTick), .extIn(extIn),
    .ovfIrq(ovfIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] aLow, input logic [15:0] v);
    wr(aLow + 3'd1, v[15:8]);
    wr(aLow, v[7:0]);
  endtask

  task automatic rdCnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd0, lo);
    rd(3'd1, hi);
    v = {hi, lo};
  endtask

  // select on, W idle cycles, select off: W+1 ticks at select 1
  task automatic run(input logic [3:0] ctrlVal, input int w);
    wr(3'd4, {4'd0, ctrlVal});
    repeat (w) @(negedge clk);
    wr(3'd4, {4'd0, ctrlVal[3], 3'd0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    int          expCnt;
    bit          expOvf;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state and unused addresses
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), b);
      check(b == 8'h00, "R10 reset read", b, 0);
    end
    check(ovfIrq == 1'b0, "R10 ovfIrq after reset", ovfIrq, 0);
    wr(3'd4, 8'hFD);
    rd(3'd4, b);
    check(b == 8'h0D, "R10 control readback", b, 8'h0D);
    wr(3'd4, 8'h00);

    // R9 compare word access
    wr16(3'd2, 16'hABCD);
    rd(3'd2, b); check(b == 8'hCD, "R9 compare low", b, 8'hCD);
    rd(3'd3, b); check(b == 8'hAB, "R9 compare high", b, 8'hAB);

    // R2 sweep compare values and run lengths
    for (int n = 0; n < 6; n++) begin
      for (int w = 0; w < 9; w++) begin
        wr16(3'd2, 16'(n));
        wr16(3'd0, 16'h0000);
        run(4'b1001, w);
        rdCnt(v);
        expCnt = (w + 1) % (n + 1);
        check(v == 16'(expCnt), "R2 match clear sweep", v, expCnt);
        check(ovfIrq == 1'b0, "R2 no flag below full scale", ovfIrq, 0);
      end
    end

    // R1/R6 free-running wrap sweep
    for (int w = 0; w < 8; w++) begin
      wr(3'd5, 8'h01);
      wr16(3'd0, 16'hFFFB);
      run(4'b0001, w);
      rdCnt(v);
      expCnt = (32'hFFFB + w + 1) & 32'hFFFF;
      expOvf = (32'hFFFB + w + 1) > 32'hFFFF;
      check(v == 16'(expCnt), "R1 free run count", v, expCnt);
      check(ovfIrq == expOvf, "R6 overflow at wrap", ovfIrq, expOvf);
    end

    // R2 count above compare runs to full scale then wraps
    wr(3'd5, 8'h01);
    wr16(3'd2, 16'h0003);
    wr16(3'd0, 16'hFFFD);
    run(4'b1001, 4);
    rdCnt(v);
    check(v == 16'h0002, "R2 above compare wraps", v, 2);
    check(ovfIrq == 1'b1, "R6 flag in match mode", ovfIrq, 1);

    // R7 write 0 keeps flag, write 1 clears
    wr(3'd5, 8'h00);
    rd(3'd5, b); check(b == 8'h01, "R7 write zero ignored", b, 1);
    wr(3'd5, 8'h01);
    rd(3'd5, b); check(b == 8'h00, "R7 write one clears", b, 0);

    // R4 prescaler taps with fixed strobe pattern 0101
    presTick = 4'b0101;
    for (int s = 2; s < 6; s++) begin
      wr16(3'd0, 16'h0000);
      run(4'(s), 5);
      rdCnt(v);
      expCnt = ((s - 2) % 2 == 0) ? 6 : 0;
      check(v == 16'(expCnt), "R4 prescaler tap", v, expCnt);
    end
    wr16(3'd0, 16'h0000);
    run(4'b0001, 5);
    rdCnt(v);
    check(v == 16'd6, "R4 direct clock", v, 6);
    presTick = 4'b0000;

    // R3 stopped: strobes and pin edges do nothing; count writable
    wr16(3'd0, 16'h1234);
    presTick = 4'b1111;
    for (int k = 0; k < 4; k++) begin
      extIn = ~extIn;
      repeat (3) @(negedge clk);
    end
    presTick = 4'b0000;
    rdCnt(v);
    check(v == 16'h1234, "R3 stopped count held", v, 16'h1234);

    // R5 external edges, rising then falling
    for (int s = 7; s >= 6; s--) begin
      wr16(3'd0, 16'h0000);
      wr(3'd4, 8'(s));
      for (int k = 0; k < 5; k++) begin
        extIn = 1'b1; repeat (4) @(negedge clk);
        extIn = 1'b0; repeat (4) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      wr(3'd4, 8'h00);
      rdCnt(v);
      check(v == 16'd5, (s == 7) ? "R5 rising edges" : "R5 falling edges", v, 5);
    end
    // R5 one edge moves count within three clocks
    wr16(3'd0, 16'h0000);
    wr(3'd4, 8'h07);
    extIn = 1'b1;
    repeat (3) @(negedge clk);
    wr(3'd4, 8'h00);
    rdCnt(v);
    check(v == 16'd1, "R5 edge latency", v, 1);
    extIn = 1'b0;
    repeat (4) @(negedge clk);

    // R8 commit while running wins over increment
    wr16(3'd0, 16'h0005);
    wr(3'd4, 8'h01);
    repeat (3) @(negedge clk);
    wr16(3'd0, 16'h4000);
    wr(3'd4, 8'h00);
    rdCnt(v);
    check(v == 16'h4001, "R8 commit beats tick", v, 16'h4001);

    // R8 commit at full scale suppresses overflow set
    wr(3'd5, 8'h01);
    wr16(3'd0, 16'hFFFE);
    wr(3'd4, 8'h01);
    wr16(3'd0, 16'h0010);
    wr(3'd4, 8'h00);
    rdCnt(v);
    check(v == 16'h0011, "R8 commit at full scale", v, 16'h0011);
    check(ovfIrq == 1'b0, "R8 overflow suppressed", ovfIrq, 0);

    // R9 temp snapshot survives a run
    wr16(3'd0, 16'h00FE);
    rd(3'd0, b); check(b == 8'hFE, "R9 low byte", b, 8'hFE);
    run(4'b0001, 4);
    rd(3'd1, b); check(b == 8'h00, "R9 high from snapshot", b, 0);
    rdCnt(v);
    check(v == 16'h0103, "R9 fresh word", v, 16'h0103);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule